// File: doc/BRIEF.md
# Per-Line Precision Data Cache

A direct-mapped, write-back data cache in which every line carries one precision flag next to its tag. Each load and store arrives marked either precise or approximate. When a miss fills a line, the line takes the precision of that access. When a later access hits, its precision is compared against the line's flag. A load whose precision differs from the line's does not get the stored word back: it gets the word XORed with a fixed nonzero pattern, which stands in for the undefined value the programming model permits.

Approximate lines can be corrupted on purpose through an error-injection port. This lets a system model reproduce the upsets that low-voltage storage would suffer. Precise lines cannot be corrupted this way. Lines are 16 bytes, made of four 32-bit words, and the default capacity is 32 KB. Requests use a valid/ready handshake. A hit responds on the next cycle. A miss holds ready low while an optional write-back and the refill run against a single-cycle line-wide memory port.

Top module: `prec_dcache`

## Requirements
- R1: After synchronous reset, req_ready is 1, resp_valid is 0 and every line is invalid, so the first access to any line misses.
- R2: A load hit whose precision equals the line's precision gives resp_valid=1 with the exact word in the cycle after acceptance, and req_ready stays 1.
- R3: A miss to an invalid or clean line drops req_ready for one cycle. In that cycle the cache reads one line (mem_valid=1, mem_write=0). The response follows two cycles after acceptance. The filled line is clean and takes the access's precision.
- R4: A miss whose victim is dirty first writes the victim's 128 data bits to memory at the victim's line address (mem_write=1). The refill follows in the next cycle, and the response comes three cycles after acceptance. No precision information goes to memory.
- R5: A load hit whose precision differs from the line's precision returns the stored word XOR 32'h5A3CC3A5.
- R6: A store hit writes its word, sets the line's precision to the store's precision and marks the line dirty, all without any memory traffic.
- R7: An injection (inject_valid=1) on an index that holds a valid approximate line XORs inject_mask into the line. Word i of the line corresponds to mask bits [32i+31:32i].
- R8: An injection is ignored when the indexed line is invalid or precise, when req_valid is 1, or when req_ready is 0.
- R9: Byte address bits [3:2] select the word, bits [4+IDX_W-1:4] select the index and the remaining upper bits form the tag. Bits [1:0] are ignored. The memory port carries word i of a line in bits [32i+31:32i].
- R10: A store miss fills the line from memory, merges the store word, leaves the line dirty with the store's precision, and responds after the same latency as a load miss.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Access request valid |
| req_ready | output | 1 | Cache can accept a request |
| req_write | input | 1 | 1 = store, 0 = load |
| req_approx | input | 1 | 1 = approximate access, 0 = precise |
| req_addr | input | ADDR_W | Byte address |
| req_wdata | input | 32 | Store data |
| resp_valid | output | 1 | One-cycle completion pulse |
| resp_rdata | output | 32 | Load result (valid with resp_valid on loads) |
| inject_valid | input | 1 | Error-injection strobe |
| inject_index | input | IDX_W | Line index to corrupt |
| inject_mask | input | 128 | Bits to flip in the line |
| mem_valid | output | 1 | Memory line transfer this cycle |
| mem_write | output | 1 | 1 = write-back, 0 = refill read |
| mem_line_addr | output | ADDR_W-4 | Line address (byte address bits above 3) |
| mem_wdata | output | 128 | Victim line data |
| mem_rdata | input | 128 | Line read data, same cycle |

## Verification
On every cycle the assertions check the miss sequencing: a write-back is always followed by a refill, a refill is always followed by a response with ready back high, memory is never driven while ready is high, and a hit responds on the next cycle. They also check that an injection and an array write never target the data store in the same cycle. Which word comes back, whether a mismatch pattern was applied, whether an injection actually landed or was dropped, and whether evicted data reaches memory intact can only be shown by the bench. Its scenarios run access sequences through a behavioural model and compare latency, ready and data against that model cycle by cycle.

// File: rtl/pcache_pkg.sv
package pcache_pkg;

    localparam int WORD_W     = 32;
    localparam int LINE_WORDS = 4;
    localparam int LINE_W     = WORD_W * LINE_WORDS;
    localparam int SEL_W      = $clog2(LINE_WORDS);
    localparam int OFF_W      = $clog2(LINE_W / 8);

    // pattern applied to a word read under the wrong precision
    localparam logic [WORD_W-1:0] MISMATCH_XOR = 32'h5A3C_C3A5;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_EVICT = 2'd1,
        ST_FILL  = 2'd2
    } pc_state_e;

    typedef struct packed {
        logic              write;
        logic              approx;
        logic [SEL_W-1:0]  sel;
        logic [WORD_W-1:0] wdata;
    } pc_op_t;

    function automatic logic [WORD_W-1:0] line_word(
        input logic [LINE_W-1:0] line,
        input logic [SEL_W-1:0]  sel
    );
        return line[sel*WORD_W +: WORD_W];
    endfunction

    function automatic logic [LINE_W-1:0] line_merge(
        input logic [LINE_W-1:0] line,
        input logic [SEL_W-1:0]  sel,
        input logic [WORD_W-1:0] w
    );
        logic [LINE_W-1:0] r;
        r = line;
        r[sel*WORD_W +: WORD_W] = w;
        return r;
    endfunction

    function automatic logic [WORD_W-1:0] precision_view(
        input logic [WORD_W-1:0] w,
        input logic              line_ap,
        input logic              acc_ap
    );
        return (line_ap != acc_ap) ? (w ^ MISMATCH_XOR) : w;
    endfunction

endpackage

// File: rtl/pc_tag_store.sv
module pc_tag_store #(
    parameter  int LINES = 2048,
    parameter  int TAG_W = 5,
    localparam int IDX_W = $clog2(LINES)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [IDX_W-1:0] rd_idx,
    output logic             rd_valid,
    output logic             rd_dirty,
    output logic             rd_approx,
    output logic [TAG_W-1:0] rd_tag,
    input  logic [IDX_W-1:0] inj_idx,
    output logic             inj_ok,
    input  logic             wr_en,
    input  logic [IDX_W-1:0] wr_idx,
    input  logic [TAG_W-1:0] wr_tag,
    input  logic             wr_approx,
    input  logic             wr_dirty
);

    logic [LINES-1:0] valid_q;
    logic [LINES-1:0] dirty_q;
    logic [LINES-1:0] approx_q;
    logic [TAG_W-1:0] tag_q [LINES];

    always_ff @(posedge clk) begin
        if (rst) begin
            valid_q <= '0;
            dirty_q <= '0;
        end else if (wr_en) begin
            valid_q[wr_idx] <= 1'b1;
            dirty_q[wr_idx] <= wr_dirty;
        end
    end

    always_ff @(posedge clk) begin
        if (wr_en) begin
            approx_q[wr_idx] <= wr_approx;
            tag_q[wr_idx]    <= wr_tag;
        end
    end

    assign rd_valid  = valid_q[rd_idx];
    assign rd_dirty  = dirty_q[rd_idx];
    assign rd_approx = approx_q[rd_idx];
    assign rd_tag    = tag_q[rd_idx];
    assign inj_ok    = valid_q[inj_idx] & approx_q[inj_idx];

endmodule

// File: rtl/pc_data_store.sv
module pc_data_store
    import pcache_pkg::*;
#(
    parameter  int LINES = 2048,
    localparam int IDX_W = $clog2(LINES)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [IDX_W-1:0]  rd_idx,
    output logic [LINE_W-1:0] rd_line,
    input  logic              wr_en,
    input  logic [IDX_W-1:0]  wr_idx,
    input  logic [LINE_W-1:0] wr_line,
    input  logic              inj_en,
    input  logic [IDX_W-1:0]  inj_idx,
    input  logic [LINE_W-1:0] inj_mask
);

    logic [LINE_W-1:0] line_q [LINES];

    always_ff @(posedge clk) begin
        if (wr_en) begin
            line_q[wr_idx] <= wr_line;
        end else if (inj_en) begin
            line_q[inj_idx] <= line_q[inj_idx] ^ inj_mask;
        end
    end

    assign rd_line = line_q[rd_idx];

    // R8
    inj_excl_chk: assert property (@(posedge clk) disable iff (rst)
        !(wr_en && inj_en));

endmodule

// File: rtl/pc_ctrl.sv
module pc_ctrl
    import pcache_pkg::*;
#(
    parameter int IDX_W = 11,
    parameter int TAG_W = 5
) (
    input  logic                   clk,
    input  logic                   rst,
    input  logic                   req_valid,
    output logic                   req_ready,
    input  pc_op_t                 req_op,
    input  logic [IDX_W-1:0]       req_idx,
    input  logic [TAG_W-1:0]       req_tag,
    output logic [IDX_W-1:0]       lk_idx,
    input  logic                   lk_valid,
    input  logic                   lk_dirty,
    input  logic                   lk_approx,
    input  logic [TAG_W-1:0]       lk_tag,
    input  logic [LINE_W-1:0]      lk_line,
    output logic                   tw_en,
    output logic [TAG_W-1:0]       tw_tag,
    output logic                   tw_approx,
    output logic                   tw_dirty,
    output logic                   dw_en,
    output logic [LINE_W-1:0]      dw_line,
    input  logic                   inj_req,
    input  logic                   inj_ok,
    output logic                   inj_fire,
    output logic                   mem_valid,
    output logic                   mem_write,
    output logic [TAG_W+IDX_W-1:0] mem_line_addr,
    output logic [LINE_W-1:0]      mem_wdata,
    input  logic [LINE_W-1:0]      mem_rdata,
    output logic                   resp_valid,
    output logic [WORD_W-1:0]      resp_rdata
);

    pc_state_e         state_q, state_d;
    pc_op_t            op_q;
    logic [IDX_W-1:0]  idx_q;
    logic [TAG_W-1:0]  tag_q;
    logic              acc_fire, hit;
    logic              resp_d, load_d;
    logic [WORD_W-1:0] rdata_d;

    assign req_ready = (state_q == ST_IDLE);
    assign acc_fire  = req_ready && req_valid;
    assign lk_idx    = req_ready ? req_idx : idx_q;
    assign hit       = lk_valid && (lk_tag == req_tag);

    always_comb begin
        state_d       = state_q;
        tw_en         = 1'b0;
        tw_tag        = req_tag;
        tw_approx     = req_op.approx;
        tw_dirty      = 1'b1;
        dw_en         = 1'b0;
        dw_line       = line_merge(lk_line, req_op.sel, req_op.wdata);
        inj_fire      = 1'b0;
        mem_valid     = 1'b0;
        mem_write     = 1'b0;
        mem_line_addr = {tag_q, idx_q};
        mem_wdata     = lk_line;
        resp_d        = 1'b0;
        load_d        = 1'b0;
        rdata_d       = precision_view(line_word(lk_line, req_op.sel),
                                       lk_approx, req_op.approx);
        unique case (state_q)
            ST_IDLE: begin
                if (acc_fire) begin
                    if (hit) begin
                        resp_d = 1'b1;
                        load_d = !req_op.write;
                        tw_en  = req_op.write;
                        dw_en  = req_op.write;
                    end else begin
                        state_d = (lk_valid && lk_dirty) ? ST_EVICT : ST_FILL;
                    end
                end else begin
                    inj_fire = inj_req && inj_ok;
                end
            end
            ST_EVICT: begin
                mem_valid     = 1'b1;
                mem_write     = 1'b1;
                mem_line_addr = {lk_tag, idx_q};
                state_d       = ST_FILL;
            end
            ST_FILL: begin
                mem_valid = 1'b1;
                tw_en     = 1'b1;
                dw_en     = 1'b1;
                tw_tag    = tag_q;
                tw_approx = op_q.approx;
                tw_dirty  = op_q.write;
                dw_line   = op_q.write ? line_merge(mem_rdata, op_q.sel, op_q.wdata)
                                       : mem_rdata;
                rdata_d   = line_word(mem_rdata, op_q.sel);
                resp_d    = 1'b1;
                load_d    = !op_q.write;
                state_d   = ST_IDLE;
            end
            default: state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q    <= ST_IDLE;
            resp_valid <= 1'b0;
            resp_rdata <= '0;
            op_q       <= '0;
            idx_q      <= '0;
            tag_q      <= '0;
        end else begin
            state_q    <= state_d;
            resp_valid <= resp_d;
            if (load_d) resp_rdata <= rdata_d;
            if (acc_fire && !hit) begin
                op_q  <= req_op;
                idx_q <= req_idx;
                tag_q <= req_tag;
            end
        end
    end

    // R2
    hit_resp_chk: assert property (@(posedge clk) disable iff (rst)
        (acc_fire && hit) |=> (resp_valid && req_ready));

    // R3
    fill_resp_chk: assert property (@(posedge clk) disable iff (rst)
        (mem_valid && !mem_write) |=> (resp_valid && req_ready));

    // R3
    busy_mem_chk: assert property (@(posedge clk) disable iff (rst)
        mem_valid |-> !req_ready);

    // R4
    evict_fill_chk: assert property (@(posedge clk) disable iff (rst)
        (mem_valid && mem_write) |=> (mem_valid && !mem_write));

    // R4
    evict_dirty_chk: assert property (@(posedge clk) disable iff (rst)
        (acc_fire && !hit && lk_valid && lk_dirty) |=> (mem_valid && mem_write));

endmodule

// File: rtl/prec_dcache.sv
module prec_dcache
    import pcache_pkg::*;
#(
    parameter  int CACHE_BYTES = 32768,
    parameter  int ADDR_W      = 20,
    localparam int LINES       = CACHE_BYTES / (LINE_W / 8),
    localparam int IDX_W       = $clog2(LINES),
    localparam int TAG_W       = ADDR_W - OFF_W - IDX_W
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  req_valid,
    output logic                  req_ready,
    input  logic                  req_write,
    input  logic                  req_approx,
    input  logic [ADDR_W-1:0]     req_addr,
    input  logic [WORD_W-1:0]     req_wdata,
    output logic                  resp_valid,
    output logic [WORD_W-1:0]     resp_rdata,
    input  logic                  inject_valid,
    input  logic [IDX_W-1:0]      inject_index,
    input  logic [LINE_W-1:0]     inject_mask,
    output logic                  mem_valid,
    output logic                  mem_write,
    output logic [ADDR_W-OFF_W-1:0] mem_line_addr,
    output logic [LINE_W-1:0]     mem_wdata,
    input  logic [LINE_W-1:0]     mem_rdata
);

    pc_op_t            op;
    logic [IDX_W-1:0]  a_idx, lk_idx;
    logic [TAG_W-1:0]  a_tag, lk_tag, tw_tag;
    logic              lk_valid, lk_dirty, lk_approx;
    logic [LINE_W-1:0] lk_line, dw_line;
    logic              tw_en, tw_approx, tw_dirty, dw_en;
    logic              inj_ok, inj_fire;
    logic              unused_byte_bits;

    assign op.write   = req_write;
    assign op.approx  = req_approx;
    assign op.sel     = req_addr[OFF_W-1 -: SEL_W];
    assign op.wdata   = req_wdata;
    assign a_idx      = req_addr[OFF_W +: IDX_W];
    assign a_tag      = req_addr[ADDR_W-1 -: TAG_W];
    assign unused_byte_bits = ^req_addr[OFF_W-SEL_W-1:0];

    pc_tag_store #(.LINES(LINES), .TAG_W(TAG_W)) u_tags (
        .clk       (clk),
        .rst       (rst),
        .rd_idx    (lk_idx),
        .rd_valid  (lk_valid),
        .rd_dirty  (lk_dirty),
        .rd_approx (lk_approx),
        .rd_tag    (lk_tag),
        .inj_idx   (inject_index),
        .inj_ok    (inj_ok),
        .wr_en     (tw_en),
        .wr_idx    (lk_idx),
        .wr_tag    (tw_tag),
        .wr_approx (tw_approx),
        .wr_dirty  (tw_dirty)
    );

    pc_data_store #(.LINES(LINES)) u_data (
        .clk      (clk),
        .rst      (rst),
        .rd_idx   (lk_idx),
        .rd_line  (lk_line),
        .wr_en    (dw_en),
        .wr_idx   (lk_idx),
        .wr_line  (dw_line),
        .inj_en   (inj_fire),
        .inj_idx  (inject_index),
        .inj_mask (inject_mask)
    );

    pc_ctrl #(.IDX_W(IDX_W), .TAG_W(TAG_W)) u_ctrl (
        .clk           (clk),
        .rst           (rst),
        .req_valid     (req_valid),
        .req_ready     (req_ready),
        .req_op        (op),
        .req_idx       (a_idx),
        .req_tag       (a_tag),
        .lk_idx        (lk_idx),
        .lk_valid      (lk_valid),
        .lk_dirty      (lk_dirty),
        .lk_approx     (lk_approx),
        .lk_tag        (lk_tag),
        .lk_line       (lk_line),
        .tw_en         (tw_en),
        .tw_tag        (tw_tag),
        .tw_approx     (tw_approx),
        .tw_dirty      (tw_dirty),
        .dw_en         (dw_en),
        .dw_line       (dw_line),
        .inj_req       (inject_valid),
        .inj_ok        (inj_ok),
        .inj_fire      (inj_fire),
        .mem_valid     (mem_valid),
        .mem_write     (mem_write),
        .mem_line_addr (mem_line_addr),
        .mem_wdata     (mem_wdata),
        .mem_rdata     (mem_rdata),
        .resp_valid    (resp_valid),
        .resp_rdata    (resp_rdata)
    );

    // R8
    inj_busy_chk: assert property (@(posedge clk) disable iff (rst)
        inj_fire |-> (req_ready && !req_valid && inj_ok));

    // R1
    resp_source_chk: assert property (@(posedge clk) disable iff (rst)
        resp_valid |-> ($past(req_valid) || $past(mem_valid)));

endmodule

// File: tb/test_prec_dcache.sv
`timescale 1ns/1ps
module test_prec_dcache;

    localparam int AW = 20;
    localparam int IW = 11;
    localparam logic [31:0] MM = 32'h5A3C_C3A5;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic         req_valid = 1'b0, req_write = 1'b0, req_approx = 1'b0;
    logic [AW-1:0] req_addr = '0;
    logic [31:0]  req_wdata = '0;
    logic         req_ready, resp_valid;
    logic [31:0]  resp_rdata;
    logic         inject_valid = 1'b0;
    logic [IW-1:0] inject_index = '0;
    logic [127:0] inject_mask = '0;
    logic         mem_valid, mem_write;
    logic [AW-5:0] mem_line_addr;
    logic [127:0] mem_wdata, mem_rdata;

    int n_chk = 0, n_fail = 0, wb_count = 0;
    bit done = 0;

    always #4 clk = ~clk;

    prec_dcache i_prec_dcache (
        .clk(clk), .rst(rst),
        .req_valid(req_valid), .req_ready(req_ready), .req_write(req_write),
        .req_approx(req_approx), .req_addr(req_addr), .req_wdata(req_wdata),
        .resp_valid(resp_valid), .resp_rdata(resp_rdata),
        .inject_valid(inject_valid), .inject_index(inject_index), .inject_mask(inject_mask),
        .mem_valid(mem_valid), .mem_write(mem_write), .mem_line_addr(mem_line_addr),
        .mem_wdata(mem_wdata), .mem_rdata(mem_rdata)
    );

    // backing memory: single-cycle, line wide
    logic [127:0] bmem [int];

    function automatic logic [127:0] seed_line(input int la);
        logic [127:0] r;
        for (int i = 0; i < 4; i++)
            r[32*i +: 32] = (la * 32'h9E37_79B1) ^ (i * 32'h0101_0101) ^ 32'hC0DE_0000;
        return r;
    endfunction

    always_comb begin
        if (bmem.exists(int'(mem_line_addr))) mem_rdata = bmem[int'(mem_line_addr)];
        else mem_rdata = seed_line(int'(mem_line_addr));
    end

    always @(posedge clk) begin
        if (!rst && mem_valid && mem_write) begin
            bmem[int'(mem_line_addr)] = mem_wdata;
            wb_count++;
        end
    end

    // behavioural reference model
    bit           mv [int];
    int           mt [int];
    bit           ma [int];
    bit           md [int];
    logic [127:0] mdat [int];
    logic [127:0] emem [int];

    function automatic logic [127:0] exp_mem(input int la);
        return emem.exists(la) ? emem[la] : seed_line(la);
    endfunction

    task automatic summary();
        if (!done) begin
            done = 1;
            $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
            $finish;
        end
    endtask

    task automatic chk(input bit ok, input string rq, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", rq, act, exp);
        end
    endtask

    task automatic access(input bit wr, input bit ap, input logic [AW-1:0] addr,
                          input logic [31:0] wd, input bit inj_during, input string rq);
        int idx, tg, w, la, lat, wb0;
        bit hit;
        logic [31:0] expv;
        idx = int'(addr[14:4]);
        tg  = int'(addr[19:15]);
        w   = int'(addr[3:2]);
        la  = int'(addr[19:4]);
        hit = mv.exists(idx) && mv[idx] && mt[idx] == tg;
        if (hit) begin
            lat = 1;
        end else begin
            if (mv.exists(idx) && mv[idx] && md[idx]) begin
                lat = 3;
                emem[(mt[idx] << 11) | idx] = mdat[idx];
            end else begin
                lat = 2;
            end
            mv[idx] = 1; mt[idx] = tg; ma[idx] = ap; md[idx] = 0;
            mdat[idx] = exp_mem(la);
        end
        expv = mdat[idx][32*w +: 32];
        if (!wr && hit && ma[idx] != ap) expv = expv ^ MM;
        if (wr) begin
            mdat[idx][32*w +: 32] = wd;
            ma[idx] = ap;
            md[idx] = 1;
        end
        wb0 = wb_count;
        req_valid = 1; req_write = wr; req_approx = ap; req_addr = addr; req_wdata = wd;
        if (inj_during) begin
            inject_valid = 1; inject_index = addr[14:4]; inject_mask = {4{32'hFFFF_0001}};
        end
        for (int k = 1; k <= lat; k++) begin
            @(negedge clk);
            chk(req_ready == (k == lat), {rq, " ready"}, 32'(req_ready), 32'(k == lat));
            chk(resp_valid == (k == lat), {rq, " resp_valid"}, 32'(resp_valid), 32'(k == lat));
            if (k == lat && !wr)
                chk(resp_rdata == expv, {rq, " data"}, resp_rdata, expv);
        end
        req_valid = 0; inject_valid = 0;
        chk((wb_count - wb0) == (lat == 3 ? 1 : 0), {rq, " writebacks"},
            32'(wb_count - wb0), 32'(lat == 3 ? 1 : 0));
    endtask

    task automatic inject(input int idx, input logic [127:0] mask);
        inject_valid = 1; inject_index = IW'(idx); inject_mask = mask;
        if (mv.exists(idx) && mv[idx] && ma[idx]) mdat[idx] = mdat[idx] ^ mask;
        @(negedge clk);
        inject_valid = 0;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog expired");
        summary();
    end

    localparam logic [AW-1:0] A  = 20'h00040;
    localparam logic [AW-1:0] B  = 20'h00080;
    localparam logic [AW-1:0] C  = 20'h000C0;
    localparam logic [AW-1:0] D  = 20'h00100;
    localparam logic [AW-1:0] TS = 20'h08000;

    initial begin
        logic [31:0] lf;
        repeat (3) @(negedge clk);
        rst = 0;
        @(negedge clk);
        // R1 reset state
        chk(req_ready == 1, "R1 ready after reset", 32'(req_ready), 1);
        chk(resp_valid == 0, "R1 resp after reset", 32'(resp_valid), 0);

        access(0, 0, A, 0, 0, "R1 R3 first load misses");
        access(0, 0, A + 4, 0, 0, "R2 precise hit");
        access(0, 0, A + 7, 0, 0, "R9 low bits ignored");
        access(0, 1, A + 12, 0, 0, "R5 approx load on precise line");
        access(1, 1, A + 8, 32'hDEAD_BEEF, 0, "R6 store hit sets approx");
        access(0, 1, A + 8, 0, 0, "R6 approx reload of stored word");
        access(0, 0, A + 8, 0, 0, "R5 precise load on approx line");

        inject(int'(A[14:4]), {32'h0000_0003, 32'h0000_0000, 32'h0100_0000, 32'h8000_0001});
        access(0, 1, A, 0, 0, "R7 injected word0");
        access(0, 1, A + 8, 0, 0, "R7 injected word2");

        access(0, 0, B, 0, 0, "R3 precise fill B");
        inject(int'(B[14:4]), {4{32'hFFFF_FFFF}});
        access(0, 0, B + 4, 0, 0, "R8 precise line not injected");
        inject(int'(C[14:4]), {4{32'h1234_5678}});
        access(0, 1, C, 0, 0, "R8 invalid line not injected");
        access(0, 1, C + 4, 0, 1, "R8 inject with req_valid high");
        access(0, 1, C + 4, 0, 0, "R8 approx line untouched after busy inject");
        access(0, 1, C + TS, 0, 1, "R8 inject during clean miss");

        access(0, 0, A + TS, 0, 0, "R4 dirty victim evicted");
        access(0, 0, A + 8, 0, 0, "R4 written-back data returns");
        access(1, 1, D + 4, 32'h0BAD_F00D, 0, "R10 store miss");
        access(0, 1, D + 4, 0, 0, "R10 merged word");
        access(0, 1, D, 0, 0, "R10 other word from memory");
        access(1, 0, D + TS, 32'h7777_0000, 0, "R10 R4 store miss evicts dirty");
        access(0, 0, D + 4, 0, 0, "R4 evicted store data");

        lf = 32'hACE1_2468;
        for (int n = 0; n < 400; n++) begin
            logic [AW-1:0] ad;
            lf = {lf[30:0], 1'b0} ^ (lf[31] ? 32'h04C1_1DB7 : 32'h0);
            ad = {3'b000, lf[1:0], 7'b0, lf[3:2], 2'b00, lf[5:4], lf[9:8]};
            if (lf[12:10] == 3'd0)
                inject(16 + int'(lf[3:2]), {lf, ~lf, lf ^ 32'h0F0F_0F0F, lf + 32'd1});
            access(lf[6], lf[7], ad, lf ^ 32'h3C3C_A5A5, lf[13] & lf[14], "R9 mixed traffic");
        end

        summary();
    end

endmodule